// File: doc/BRIEF.md
# Interrupt Claim/Complete Controller

This block gathers level-triggered interrupt requests from a set of sources and presents them to one target. Each source has a gateway that latches a request into a pending bit. Each source also carries a programmable priority and an enable bit. A single interrupt line to the target is raised whenever some source is worth servicing. The target claims a source by reading one register. That read returns the winning source ID and, in the same cycle, moves the source from pending to in service. The target finishes by writing the same ID back to that register, which is the completion.

A completion takes effect only while the named source is enabled. A selectable auto-mask mode also drops a source's enable bit when it is claimed. So in that mode, and whenever software masks a source it is still handling, the source stays in service. No new request is taken from it until it is enabled again and a second completion arrives. Other sources keep flowing while one source is blocked.

Top module: `irq_claim_ctrl`

## Requirements
- R1: A read with address bits [5:4] = 0 (claim register) returns, on the clock after the read, the ID of the enabled, pending source with the largest nonzero priority. Ties go to the lowest ID. The value is 0 when no such source exists.
- R2: A claim clears the winner's pending bit in the cycle of the read, so the next read cannot return that ID again.
- R3: A completion write (bank 0, ID in write data) naming a source whose enable bit is 0 is ignored, and the source stays in service.
- R4: With auto_mask=1, a claim clears the winner's enable bit. With auto_mask=0, the enable bit is unchanged. Both are visible by reading the enable bank.
- R5: A source in service blocks only itself. Other pending, enabled sources can still be claimed.
- R6: A source masked while in service is released only by a completion written after it has been re-enabled. Re-enabling alone does not release it.
- R7: A source with priority 0 never raises irq and is never returned by a claim.
- R8: Completion writes naming ID 0, or an ID above N_SRC, change nothing.
- R9: irq is 1 exactly when some source is pending, enabled and has nonzero priority.
- R10: Register map: address bits [5:4] select the bank (0 claim/complete, 1 priority, 2 enable) and bits [3:0] give the source ID. Priority is data bits [2:0] and enable is data bit 0. After reset all priorities and enables are 0, and irq and read data are 0.
- R11: src_irq bit k is source ID k+1. A level still high after an honoured completion sets pending again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_mask | input | 1 | 1: a claim also clears the source's enable bit |
| src_irq | input | N_SRC | Level requests, bit k is source ID k+1 |
| reg_valid | input | 1 | Register access this cycle |
| reg_write | input | 1 | 1 write, 0 read |
| reg_addr | input | ID_W+2 | Bank in top two bits, source ID below |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the clock after a read |
| irq | output | 1 | Interrupt request to the target |

## Verification
The hardest state to reach is a source that is in service and masked, with its level still high. The bench also has to show that a completion followed by re-enabling, with no second completion, leaves it silent. The stimulus claims a source in standard mode, clears its enable, writes a completion, and re-enables it. It then checks that irq stays low and a claim returns 0, and only after a second completion does the same ID reappear. The auto-mask path reaches the same state without any enable write, and the enable bank is read back to prove the bit fell.

// File: rtl/icc_pkg.sv
package icc_pkg;

  typedef enum logic [1:0] {
    BK_CC   = 2'd0,
    BK_PRIO = 2'd1,
    BK_EN   = 2'd2,
    BK_RSVD = 2'd3
  } bank_e;

  // Source slot s (0-based) answers to ID s+1; ID 0 never matches.
  function automatic logic id_matches(int unsigned id, int unsigned slot);
    return id == slot + 1;
  endfunction

  // Strict comparison: an equal priority at a later slot does not win.
  function automatic logic beats(int unsigned cand, int unsigned best);
    return cand > best;
  endfunction

endpackage

// File: rtl/icc_gateway.sv
module icc_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic claim_i,
  input  logic done_i,
  output logic pending_o,
  output logic busy_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_o <= 1'b0;
      busy_o    <= 1'b0;
    end else if (claim_i) begin
      pending_o <= 1'b0;
      busy_o    <= 1'b1;
    end else begin
      if (done_i) busy_o <= 1'b0;
      if (level_i && !busy_o && !pending_o) pending_o <= 1'b1;
    end
  end

  // R2: a claim empties pending and marks the source in service
  p_claim_drops_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |=> (!pending_o && busy_o));

  // R5: nothing is accepted while the source is in service
  p_quiet_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !pending_o);

endmodule

// File: rtl/icc_arbiter.sv
module icc_arbiter #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 4
) (
  input  logic [N_SRC-1:0]  req_i,
  input  logic [PRIO_W-1:0] prio_i [N_SRC],
  output logic [ID_W-1:0]   win_id_o
);
  import icc_pkg::*;

  logic [PRIO_W-1:0] best_p;

  always_comb begin
    best_p   = '0;
    win_id_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && beats(32'(prio_i[i]), 32'(best_p))) begin
        best_p   = prio_i[i];
        win_id_o = ID_W'(i + 1);
      end
    end
  end

endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl #(
  parameter  int N_SRC  = 8,
  parameter  int PRIO_W = 3,
  localparam int ID_W   = $clog2(N_SRC + 1),
  localparam int ADDR_W = ID_W + 2,
  localparam int DATA_W = (ID_W > PRIO_W) ? ID_W : PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_mask,
  input  logic [N_SRC-1:0]  src_irq,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  import icc_pkg::*;

  bank_e            bank;
  logic [ID_W-1:0]  slot_id;
  logic [ID_W-1:0]  done_id;
  logic [ID_W-1:0]  win_id;
  logic             acc_claim, acc_done, acc_prio, acc_en;

  logic [PRIO_W-1:0] prio_q [N_SRC];
  logic [N_SRC-1:0]  en_q;
  logic [N_SRC-1:0]  pend, busy, live;
  logic [N_SRC-1:0]  claim_vec, done_hot, done_vec, slot_hot;
  logic [DATA_W-1:0] rd_mux;

  assign bank      = bank_e'(reg_addr[ADDR_W-1 -: 2]);
  assign slot_id   = reg_addr[ID_W-1:0];
  assign done_id   = reg_wdata[ID_W-1:0];
  assign acc_claim = reg_valid && !reg_write && (bank == BK_CC);
  assign acc_done  = reg_valid &&  reg_write && (bank == BK_CC);
  assign acc_prio  = reg_valid &&  reg_write && (bank == BK_PRIO);
  assign acc_en    = reg_valid &&  reg_write && (bank == BK_EN);

  // Named per-source events
  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      live[i]      = pend[i] && en_q[i] && (prio_q[i] != '0);
      claim_vec[i] = acc_claim && id_matches(32'(win_id), i);
      done_hot[i]  = acc_done && id_matches(32'(done_id), i);
      done_vec[i]  = done_hot[i] && en_q[i];
      slot_hot[i]  = id_matches(32'(slot_id), i);
    end
  end

  assign irq = |live;

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
      icc_gateway u_gw (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_i   (src_irq[g]),
        .claim_i   (claim_vec[g]),
        .done_i    (done_vec[g]),
        .pending_o (pend[g]),
        .busy_o    (busy[g])
      );
    end
  endgenerate

  icc_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .req_i    (pend & en_q),
    .prio_i   (prio_q),
    .win_id_o (win_id)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int i = 0; i < N_SRC; i++) prio_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_SRC; i++) begin
        if (acc_prio && slot_hot[i]) prio_q[i] <= reg_wdata[PRIO_W-1:0];
        if (acc_en && slot_hot[i])   en_q[i]   <= reg_wdata[0];
        else if (claim_vec[i] && auto_mask) en_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bank)
      BK_CC:   rd_mux = DATA_W'(win_id);
      BK_PRIO: for (int i = 0; i < N_SRC; i++)
                 if (slot_hot[i]) rd_mux = DATA_W'(prio_q[i]);
      BK_EN:   for (int i = 0; i < N_SRC; i++)
                 if (slot_hot[i]) rd_mux = DATA_W'(en_q[i]);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        reg_rdata <= '0;
    else if (reg_valid && !reg_write)  reg_rdata <= rd_mux;
  end

  // R1: a claim made with nothing to service reads back zero
  p_empty_claim_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_claim && !irq) |=> (reg_rdata == '0));

  // R3: completion of a disabled in-service source leaves it in service
  p_masked_done_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && |(done_hot & ~en_q & busy)) |=> |($past(done_hot & ~en_q & busy) & busy));

  // R4: auto-mask drops the enable of the claimed source
  p_automask_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_claim && auto_mask && |claim_vec) |=> ((en_q & $past(claim_vec)) == '0));

  // R4: standard mode keeps the enable of the claimed source
  p_std_keeps_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_claim && !auto_mask && |claim_vec) |=> ((en_q & $past(claim_vec)) == $past(claim_vec)));

  // R7: the winner never has priority zero
  p_no_zero_winner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    |(claim_vec & live) == |claim_vec);

endmodule

// File: tb/tb_irq_claim_ctrl.sv
module tb_irq_claim_ctrl;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       auto_mask = 1'b0;
  logic [N-1:0] src_irq = '0;
  logic       reg_valid = 1'b0, reg_write = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [3:0] reg_wdata = '0;
  logic [3:0] reg_rdata;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  int    exp_q[$];
  string tag_q[$];
  logic  rd_seen = 1'b0;

  always #10 clk = ~clk;

  irq_claim_ctrl dut (
    .clk(clk), .rst_n(rst_n), .auto_mask(auto_mask), .src_irq(src_irq),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [5:0] adr(int bank, int id);
    return {2'(bank), 4'(id)};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int bank, int id, int data);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = adr(bank, id); reg_wdata = 4'(data);
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  // Driver: issue a read and push the expected value for the monitor
  task automatic rd(int bank, int id, int expv, string tag);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = adr(bank, id);
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic chk(int act, int expv, string tag);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Monitor: pop one expected item per completed read
  always @(posedge clk) rd_seen <= rst_n && reg_valid && !reg_write;

  always @(negedge clk) begin
    if (rd_seen) begin
      int e;
      string t;
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL monitor actual=%0d expected=none", reg_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(reg_rdata), e, t);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R10 reset state
    chk(irq, 0, "R10 irq after reset");
    rd(1, 1, 0, "R10 priority reset");
    rd(2, 1, 0, "R10 enable reset");
    rd(0, 0, 0, "R1 empty claim");

    wr(1, 1, 2); wr(1, 2, 5); wr(1, 3, 5); wr(1, 4, 0);
    for (int i = 1; i <= 4; i++) wr(2, i, 1);
    rd(1, 2, 5, "R10 priority readback");
    src_irq[3:0] = 4'hF;
    tick(2);
    chk(irq, 1, "R9 irq with live source");
    rd(0, 0, 2, "R1 highest priority, tie to lowest ID");
    rd(0, 0, 3, "R2 R5 second claim skips busy source");
    rd(0, 0, 1, "R1 lower priority next");
    rd(0, 0, 0, "R7 priority zero never claimed");
    tick(1);
    chk(irq, 0, "R7 R9 irq low with only priority-zero pending");
    rd(2, 2, 1, "R4 standard mode keeps enable");

    wr(0, 0, 0); wr(0, 0, 12);
    tick(2);
    chk(irq, 0, "R8 bad IDs release nothing");
    rd(0, 0, 0, "R8 claim empty after bad IDs");
    wr(0, 0, 2);
    tick(2);
    chk(irq, 1, "R11 level re-pends after completion");
    rd(0, 0, 2, "R11 reclaim after completion");

    wr(2, 2, 0);
    wr(0, 0, 2);
    wr(2, 2, 1);
    tick(2);
    chk(irq, 0, "R3 R6 masked completion ignored");
    rd(0, 0, 0, "R3 R6 source still held");
    wr(0, 0, 2);
    tick(2);
    rd(0, 0, 2, "R6 released after enabled completion");

    src_irq = '0;
    wr(0, 0, 1); wr(0, 0, 2); wr(0, 0, 3);
    tick(2);
    chk(irq, 0, "R9 irq low with levels dropped");
    auto_mask = 1'b1;
    wr(1, 5, 3); wr(2, 5, 1);
    src_irq[4] = 1'b1;
    tick(2);
    rd(0, 0, 5, "R4 auto-mask claim");
    rd(2, 5, 0, "R4 auto-mask cleared enable");
    wr(0, 0, 5);
    wr(2, 5, 1);
    tick(2);
    chk(irq, 0, "R3 auto-masked completion ignored");
    rd(0, 0, 0, "R6 still blocked after re-enable");
    wr(0, 0, 5);
    tick(2);
    rd(0, 0, 5, "R6 R11 returns after enabled completion");
    tick(3);
    finish_run();
  end
endmodule